// File: doc/BRIEF.md
# Two-Level Strided Address Generator

This block walks the byte addresses of one block of data elements. A block is made of microblocks, and a microblock is made of elements. Each element is 1, 2, 4 or 8 bytes wide. The caller loads a start address, an element size, an addressing mode, the two lengths and two signed strides. After that, every accepted step pulse moves the address to the next element. One stride is applied between elements inside a microblock. The other is applied when the walk crosses from one microblock into the next. Both strides are signed, so the same logic can leave gaps, make accesses overlap, hold on one element, walk backwards, or turn a square byte array through a quarter turn.

A transfer engine uses two copies of the block, one for the read side and one for the write side. Each copy has its own mode and its own strides. The engine watches the microblock-end and block-end flags to know where it is in the block, and the generator goes idle after the step that consumes the last element. The memory accesses themselves are made elsewhere.

Top module: `stride_addr_gen`

## Requirements
- R1: After a synchronous active-high reset, `busy` is 0, `addr` is 0, and `ublk_end` and `blk_end` are 0.
- R2: A cycle with `load` high starts a new block, even while an earlier block is still running. In the next cycle `addr` equals `start_addr` and `busy` is 1. When `load` and `step` are both high, `load` wins.
- R3: Mode code 0 (fixed): every step leaves `addr` unchanged.
- R4: Mode code 1 (incrementing): every step adds the element size to `addr`. The element size is 2^`size_log2` bytes, so codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R5: Mode code 2 (microblock stride): inside a microblock a step adds the element size. A step from the last element of a microblock adds the element size plus the microblock stride.
- R6: Mode code 3 (microblock and data stride): inside a microblock a step adds the element size plus the data stride. At a microblock boundary a step adds the element size plus the microblock stride.
- R7: Both strides are 24-bit two's-complement values, sign-extended to 32 bits. All address arithmetic wraps modulo 2^32. A data stride of -1 with 1-byte elements therefore holds the address. A microblock stride of minus the microblock length (with 1-byte elements) walks the same microblock again.
- R8: `ublk_end` is 1 exactly while the current element is the last one of its microblock. `ublen_m1` holds the number of elements per microblock minus one.
- R9: `blk_end` is 1 exactly while the current element is the last element of the last microblock. `blen_m1` holds the number of microblocks minus one.
- R10: A step taken while `blk_end` is 1 ends the block. In the next cycle `busy`, `ublk_end` and `blk_end` are 0 and `addr` keeps its last value. A step while idle changes nothing.
- R11: The mode, size, length, stride and start inputs are read only in a load cycle. Changing them during a block has no effect on the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start a new block with the configuration on the inputs below |
| start_addr | input | 32 | Byte address of the first element |
| size_log2 | input | 2 | Element size code, size is 2^code bytes |
| mode | input | 2 | Addressing mode: 0 fixed, 1 incrementing, 2 microblock stride, 3 microblock and data stride |
| ublen_m1 | input | 8 | Elements per microblock, minus one |
| blen_m1 | input | 8 | Microblocks per block, minus one |
| data_stride | input | 24 | Signed byte gap between elements |
| ublk_stride | input | 24 | Signed byte gap between microblocks |
| step | input | 1 | Advance to the next element |
| addr | output | 32 | Byte address of the current element |
| ublk_end | output | 1 | Current element closes its microblock |
| blk_end | output | 1 | Current element closes the block |
| busy | output | 1 | A block is in progress |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 24-bit strides and 8-bit length fields. It sweeps every mode, every element-size code, microblock and block counts from one to three, and three stride pairs. The pairs cover zero strides, a positive data stride with a negative microblock stride, and a data stride of -1. This brings every boundary combination within reach, including single-element microblocks and single-microblock blocks. Separate runs cover wrap-around past the top of the address space, re-reading a microblock, the most negative stride, a restart in the middle of a block, idle steps, and the quarter-turn walks of a 10x10 byte array in both directions.

// File: rtl/stride_pkg.sv
package stride_pkg;
  typedef enum logic [1:0] {
    AM_FIXED     = 2'd0,
    AM_INCR      = 2'd1,
    AM_UBLK      = 2'd2,
    AM_UBLK_DATA = 2'd3
  } am_mode_t;
endpackage

// File: rtl/stride_delta.sv
// Picks the address increment for an in-microblock step and a boundary step.
module stride_delta
  import stride_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 24
) (
  input  am_mode_t              mode,
  input  logic [1:0]            size_log2,
  input  logic [STRIDE_W-1:0]   data_stride,
  input  logic [STRIDE_W-1:0]   ublk_stride,
  output logic [ADDR_W-1:0]     elem_delta,
  output logic [ADDR_W-1:0]     ublk_delta
);
  localparam int EXT_W = ADDR_W - STRIDE_W;

  logic [ADDR_W-1:0] size_bytes;
  logic [ADDR_W-1:0] ds_ext;
  logic [ADDR_W-1:0] us_ext;

  assign size_bytes = ADDR_W'(1) << size_log2;
  assign ds_ext     = {{EXT_W{data_stride[STRIDE_W-1]}}, data_stride};
  assign us_ext     = {{EXT_W{ublk_stride[STRIDE_W-1]}}, ublk_stride};

  always_comb begin
    unique case (mode)
      AM_FIXED: begin
        elem_delta = '0;
        ublk_delta = '0;
      end
      AM_INCR: begin
        elem_delta = size_bytes;
        ublk_delta = size_bytes;
      end
      AM_UBLK: begin
        elem_delta = size_bytes;
        ublk_delta = size_bytes + us_ext;
      end
      default: begin
        elem_delta = size_bytes + ds_ext;
        ublk_delta = size_bytes + us_ext;
      end
    endcase
  end
endmodule

// File: rtl/stride_count.sv
// Wrapping counter that keeps a registered look-ahead "at last value" flag.
module stride_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] last_in,
  output logic         at_last
);
  logic [W-1:0] count_q;
  logic [W-1:0] last_q;
  logic [W-1:0] count_inc;

  assign count_inc = count_q + W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      last_q  <= '0;
      at_last <= 1'b0;
    end else if (clr) begin
      count_q <= '0;
      last_q  <= last_in;
      at_last <= (last_in == '0);
    end else if (adv) begin
      if (at_last) begin
        count_q <= '0;
        at_last <= (last_q == '0);
      end else begin
        count_q <= count_inc;
        at_last <= (count_inc == last_q);
      end
    end
  end
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
  import stride_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 24,
  parameter int UBLEN_W  = 8,
  parameter int BLEN_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [1:0]          size_log2,
  input  logic [1:0]          mode,
  input  logic [UBLEN_W-1:0]  ublen_m1,
  input  logic [BLEN_W-1:0]   blen_m1,
  input  logic [STRIDE_W-1:0] data_stride,
  input  logic [STRIDE_W-1:0] ublk_stride,
  input  logic                step,
  output logic [ADDR_W-1:0]   addr,
  output logic                ublk_end,
  output logic                blk_end,
  output logic                busy
);
  am_mode_t            mode_q;
  logic [1:0]          size_q;
  logic [STRIDE_W-1:0] ds_q;
  logic [STRIDE_W-1:0] us_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                busy_q;

  logic                elem_last;
  logic                ublk_last;
  logic                last_of_blk;
  logic                step_ok;
  logic [ADDR_W-1:0]   elem_delta;
  logic [ADDR_W-1:0]   ublk_delta;

  assign step_ok     = step & busy_q & ~load;
  assign last_of_blk = elem_last & ublk_last;

  // configuration is captured only when a block starts
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= AM_FIXED;
      size_q <= '0;
      ds_q   <= '0;
      us_q   <= '0;
    end else if (load) begin
      mode_q <= am_mode_t'(mode);
      size_q <= size_log2;
      ds_q   <= data_stride;
      us_q   <= ublk_stride;
    end
  end

  stride_delta #(
    .ADDR_W   (ADDR_W),
    .STRIDE_W (STRIDE_W)
  ) u_delta (
    .mode        (mode_q),
    .size_log2   (size_q),
    .data_stride (ds_q),
    .ublk_stride (us_q),
    .elem_delta  (elem_delta),
    .ublk_delta  (ublk_delta)
  );

  // element position inside the microblock
  stride_count #(.W(UBLEN_W)) u_elem_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (load),
    .adv     (step_ok & ~last_of_blk),
    .last_in (ublen_m1),
    .at_last (elem_last)
  );

  // microblock position inside the block
  stride_count #(.W(BLEN_W)) u_ublk_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (load),
    .adv     (step_ok & elem_last & ~ublk_last),
    .last_in (blen_m1),
    .at_last (ublk_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      addr_q <= start_addr;
      busy_q <= 1'b1;
    end else if (step_ok) begin
      if (last_of_blk) begin
        busy_q <= 1'b0;
      end else begin
        addr_q <= addr_q + (elem_last ? ublk_delta : elem_delta);
      end
    end
  end

  assign addr     = addr_q;
  assign busy     = busy_q;
  assign ublk_end = busy_q & elem_last;
  assign blk_end  = busy_q & last_of_blk;
endmodule

// File: rtl/stride_addr_gen_chk.sv
module stride_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [ADDR_W-1:0] start_addr,
  input logic              step,
  input logic [ADDR_W-1:0] addr,
  input logic              ublk_end,
  input logic              blk_end,
  input logic              busy,
  input logic [1:0]        mode_q,
  input logic [1:0]        size_q
);
  p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> busy && addr == $past(start_addr));

  p_fixed_hold_r3: assert property (@(posedge clk) disable iff (rst)
    busy && !load && step && mode_q == 2'd0 |=> addr == $past(addr));

  p_incr_step_r4: assert property (@(posedge clk) disable iff (rst)
    busy && !load && step && !blk_end && mode_q == 2'd1
    |=> addr == $past(addr) + (ADDR_W'(1) << $past(size_q)));

  p_blk_has_ublk_r9: assert property (@(posedge clk) disable iff (rst)
    blk_end |-> ublk_end);

  p_idle_flags_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ublk_end && !blk_end);

  p_end_idle_r10: assert property (@(posedge clk) disable iff (rst)
    busy && blk_end && step && !load |=> !busy && $stable(addr));

  p_idle_step_r10: assert property (@(posedge clk) disable iff (rst)
    !busy && !load |=> !busy && $stable(addr));
endmodule

bind stride_addr_gen stride_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load       (load),
  .start_addr (start_addr),
  .step       (step),
  .addr       (addr),
  .ublk_end   (ublk_end),
  .blk_end    (blk_end),
  .busy       (busy),
  .mode_q     (mode_q),
  .size_q     (size_q)
);

// File: tb/test_stride_addr_gen.sv
`timescale 1ns/1ps
module test_stride_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [31:0] start_addr = '0;
  logic [1:0]  size_log2 = '0;
  logic [1:0]  mode = '0;
  logic [7:0]  ublen_m1 = '0;
  logic [7:0]  blen_m1 = '0;
  logic [23:0] data_stride = '0;
  logic [23:0] ublk_stride = '0;
  logic        step = 1'b0;
  logic [31:0] addr;
  logic        ublk_end;
  logic        blk_end;
  logic        busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stride_addr_gen i_stride_addr_gen (
    .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
    .size_log2(size_log2), .mode(mode), .ublen_m1(ublen_m1), .blen_m1(blen_m1),
    .data_stride(data_stride), .ublk_stride(ublk_stride), .step(step),
    .addr(addr), .ublk_end(ublk_end), .blk_end(blk_end), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] st, input logic [1:0] sz,
      input logic [1:0] md, input int ne, input int u, input int e,
      input logic [23:0] ds, input logic [23:0] us);
    logic [31:0] s, de, du;
    s = 32'd1 << sz;
    case (md)
      2'd0: begin de = 0; du = 0; end
      2'd1: begin de = s; du = s; end
      2'd2: begin de = s; du = s + {{8{us[23]}}, us}; end
      default: begin de = s + {{8{ds[23]}}, ds}; du = s + {{8{us[23]}}, us}; end
    endcase
    return st + 32'(u) * (32'(ne - 1) * de + du) + 32'(e) * de;
  endfunction

  // Runs one whole block; config inputs are scrambled after the load (R11).
  task automatic run_block(input logic [31:0] st, input logic [1:0] sz, input logic [1:0] md,
      input int ne, input int nb, input logic [23:0] ds, input logic [23:0] us, input string tag);
    logic [31:0] e_a;
    e_a = st;
    @(negedge clk);
    load = 1'b1; step = 1'b0; start_addr = st; size_log2 = sz; mode = md;
    ublen_m1 = 8'(ne - 1); blen_m1 = 8'(nb - 1); data_stride = ds; ublk_stride = us;
    @(negedge clk);
    load = 1'b0;
    start_addr = ~st; size_log2 = ~sz; mode = ~md; ublen_m1 = ~ublen_m1;
    blen_m1 = ~blen_m1; data_stride = ~ds; ublk_stride = ~us;
    for (int u = 0; u < nb; u++) begin
      for (int e = 0; e < ne; e++) begin
        e_a = exp_addr(st, sz, md, ne, u, e, ds, us);
        chk({tag, " addr /R11"}, addr, e_a);
        chk("R2 busy", 32'(busy), 32'd1);
        chk("R8 ublk_end", 32'(ublk_end), 32'(e == ne - 1));
        chk("R9 blk_end", 32'(blk_end), 32'(e == ne - 1 && u == nb - 1));
        step = 1'b1;
        @(negedge clk);
      end
    end
    step = 1'b0;
    chk("R10 busy after end", 32'(busy), 32'd0);
    chk("R10 addr held", addr, e_a);
    chk("R10 flags low", 32'({ublk_end, blk_end}), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string mtag [4];
    logic [23:0] ds_set [3];
    logic [23:0] us_set [3];
    logic [31:0] held;
    mtag = '{"R3", "R4", "R5", "R6"};
    ds_set = '{24'd0, 24'd5, 24'hFFFFFF};
    us_set = '{24'd0, 24'hFFFFF9, 24'h000010};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 addr", addr, 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 flags", 32'({ublk_end, blk_end}), 32'd0);

    // Sweep of modes, sizes, lengths and strides (R3 R4 R5 R6 R8 R9)
    for (int md = 0; md < 4; md++)
      for (int sz = 0; sz < 4; sz++)
        for (int ne = 1; ne <= 3; ne++)
          for (int nb = 1; nb <= 3; nb++)
            for (int k = 0; k < 3; k++)
              run_block(32'h1000 + 32'(k * 256), 2'(sz), 2'(md), ne, nb,
                        ds_set[k], us_set[k], mtag[md]);

    // R7: wrap modulo 2^32, hold with -1, re-read with -UBLEN, extreme stride
    run_block(32'hFFFF_FFF8, 2'd2, 2'd1, 4, 1, 24'd0, 24'd0, "R7 wrap");
    run_block(32'd100, 2'd0, 2'd3, 4, 2, 24'hFFFFFF, 24'd3, "R7 hold");
    run_block(32'd100, 2'd0, 2'd2, 4, 3, 24'd0, 24'hFFFFFC, "R7 reread");
    run_block(32'h0000_0010, 2'd0, 2'd3, 2, 2, 24'h800000, 24'h7FFFFF, "R7 extreme");

    // R6: quarter turns of a 10x10 byte array
    run_block(32'd9, 2'd0, 2'd3, 10, 10, 24'd9, 24'hFFFFA4, "R6 rotate right");
    run_block(32'd90, 2'd0, 2'd3, 10, 10, 24'hFFFFF5, 24'd90, "R6 rotate left");

    // R10: steps while idle change nothing
    held = addr;
    step = 1'b1;
    repeat (3) @(negedge clk);
    step = 1'b0;
    chk("R10 idle addr", addr, held);
    chk("R10 idle busy", 32'(busy), 32'd0);

    // R2: restart mid block, load wins over step
    @(negedge clk);
    load = 1'b1; start_addr = 32'h200; mode = 2'd1; size_log2 = 2'd0;
    ublen_m1 = 8'd7; blen_m1 = 8'd0;
    @(negedge clk);
    load = 1'b0; step = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 mid-block addr", addr, 32'h202);
    load = 1'b1; start_addr = 32'h500;
    @(negedge clk);
    load = 1'b0; step = 1'b0;
    chk("R2 restart addr", addr, 32'h500);
    chk("R2 restart busy", 32'(busy), 32'd1);
    chk("R8 restart ublk_end", 32'(ublk_end), 32'd0);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk("R4 after restart", addr, 32'h501);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule